// File: doc/BRIEF.md
# PWM Fault Latch Controller

This block sits between three PWM generators and the six output pins they drive. Each generator supplies a complementary high and low signal. The block passes them to the pins through one output register. When a protection input asserts, it replaces them with a safe level programmed for each pair. Each pair has its own fault input and its own current-limit input. A further fail-safe fault input covers all three pairs.

The fail-safe fault leaves every reset armed and latched, so the pins hold their safe levels from power-up until software clears it. Each fault input has a mode that software selects: latched, cycle-by-cycle or disabled. A latched fault clears only on a clear strobe that arrives while its synchronised input is low. Software may rewrite the mode of any fault at any time, including while that fault is active. The current limits always act cycle-by-cycle. A sticky status bit for each fault records that the fault fired, and it holds until a clear succeeds.

Writes use one strobe, a target index and data fields. Index 0 to 2 picks a pair and writes both its fault mode and its safe levels. Index 3 picks the fail-safe fault and writes its mode only. A period boundary strobe from the generators times the cycle-by-cycle releases.

Top module: `pwm_fault_guard`

## Requirements
- R1: On any reset, the fail-safe fault becomes active in latched mode and its status bit is set. Every pair's safe levels reset to 00 and every pair's fault mode resets to disabled. The pins therefore show low on all six outputs until software clears the fail-safe fault.
- R2: While the fail-safe fault is active, every pair drives its own safe levels. A clear on clr_i[3] while that input is low releases all pairs.
- R3: A clear strobe that arrives while the fault input's synchronised level is high has no effect. The fault stays active and the pins stay at their safe levels.
- R4: A mode written while the fault is active and its input is high takes effect. After a switch from latched to cycle-by-cycle, the fault releases at a period boundary with no clear.
- R5: Mode 00 (latched) sets on the fault input and stays set through period boundaries after the input falls. It releases only on a clear strobe that arrives with the input low.
- R6: Mode 01 (cycle-by-cycle) stays set while the input is high and does not release before a period boundary. It releases at the first tick_i pulse that finds the input low.
- R7: Mode 10 behaves exactly as mode 00.
- R8: Mode 11 (disabled) ignores the fault input. Neither the pins nor the status bit change.
- R9: A current-limit input forces its pair to the safe levels whatever the pair's fault mode, and releases cycle-by-cycle. It does not set any status bit.
- R10: A rising fault or current-limit input first shows at the pins after the 4th rising clock edge: two synchroniser stages, one state register and one output register. The status bit sets one edge earlier. A raw PWM change shows at the pins one edge later.
- R11: With no override active and pwm_en_i low, both outputs of every pair are 0.
- R12: A status bit stays set until a clear strobe for that fault arrives while its input is low, whatever the fault's mode.
- R13: Bit 1 of a pair's safe-level field is the level for its high output and bit 0 is the level for its low output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_hi_i | input | 3 | Raw high-side signal of each pair |
| pwm_lo_i | input | 3 | Raw low-side signal of each pair |
| flt_i | input | 3 | Fault input of each pair, active high |
| clim_i | input | 3 | Current-limit input of each pair, active high |
| fs_flt_i | input | 1 | Fail-safe fault input, active high |
| tick_i | input | 1 | PWM period boundary strobe |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 to 2 for a pair, 3 for the fail-safe fault |
| wr_mode_i | input | 2 | Fault mode: 00 latched, 01 cycle-by-cycle, 10 latched, 11 disabled |
| wr_safe_i | input | 2 | Safe levels {high, low}, written for pair targets only |
| clr_i | input | 4 | Clear strobes: bits 0 to 2 for the pairs, bit 3 for the fail-safe fault |
| pwm_en_i | input | 1 | Lets the raw signals through when no override is active |
| pwm_hi_o | output | 3 | Gated high-side outputs |
| pwm_lo_o | output | 3 | Gated low-side outputs |
| flt_stat_o | output | 3 | Sticky status of each pair's fault |
| fs_stat_o | output | 1 | Sticky status of the fail-safe fault |

## Verification
A wrong fault state shows at the pins one edge after the state register. A missed set leaves raw PWM at the pins four edges after the input rises. A clear accepted while the input is high releases the pins at the next edge instead of holding them. A lost cycle-by-cycle state shows as a release with no tick or as no release after a tick, and a faulty status register shows directly on its bit. The scoreboard therefore compares the pins and the status bits at the exact edge each change is due. It also compares them in the cycles where nothing may change.

// File: rtl/pwm_fg_pkg.sv
// Shared types for the PWM fault guard.
// Assumes the fault mode field is two bits wide, with the encodings below.
package pwm_fg_pkg;

    typedef enum logic [1:0] {
        FM_LATCH = 2'b00,
        FM_CBC   = 2'b01,
        FM_RSVD  = 2'b10,
        FM_OFF   = 2'b11
    } fmode_e;

    localparam int SYNC_STAGES = 2;

    // True for the modes that wait for a software clear.
    function automatic logic mode_latches(fmode_e m);
        return (m == FM_LATCH) || (m == FM_RSVD);
    endfunction

endpackage

// File: rtl/pwm_fg_sync.sv
// Multi-stage synchroniser for asynchronous active-high inputs.
// Assumes every bit is independent. All stages reset to 0.
module pwm_fg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    // Shift each input through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/pwm_fg_cell.sv
// One fault channel: its mode register, its active state and its sticky status.
// Assumes flt_s is already synchronised. Parameters set the reset state,
// so the same cell serves both pair faults and the fail-safe fault.
module pwm_fg_cell
    import pwm_fg_pkg::*;
#(
    parameter logic   RST_ACTIVE = 1'b0,
    parameter fmode_e RST_MODE   = FM_OFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flt_s,
    input  logic       tick,
    input  logic       mode_wr,
    input  logic [1:0] mode_wdata,
    input  logic       clr,
    output logic       active_o,
    output logic       sticky_o
);

    fmode_e mode_q;
    logic   active_q, active_d;
    logic   sticky_q, sticky_d;
    logic   armed, clear_hit;

    // Decode the mode and whether a clear request is honoured.
    always_comb begin
        armed     = (mode_q != FM_OFF);
        clear_hit = clr && !flt_s;
    end

    // Next active state from the mode, the input, the clear and the tick.
    always_comb begin
        if (!armed)                   active_d = 1'b0;
        else if (flt_s)               active_d = 1'b1;
        else if (mode_latches(mode_q)) active_d = clear_hit ? 1'b0 : active_q;
        else                          active_d = tick ? 1'b0 : active_q;
    end

    // The sticky status is set by an armed fault and dropped by a valid clear.
    always_comb begin
        if (armed && flt_s)  sticky_d = 1'b1;
        else if (clear_hit)  sticky_d = 1'b0;
        else                 sticky_d = sticky_q;
    end

    // State registers. The mode may be rewritten at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= RST_MODE;
            active_q <= RST_ACTIVE;
            sticky_q <= RST_ACTIVE;
        end else begin
            if (mode_wr) mode_q <= fmode_e'(mode_wdata);
            active_q <= active_d;
            sticky_q <= sticky_d;
        end
    end

    assign active_o = active_q;
    assign sticky_o = sticky_q;

    // R3
    clr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && flt_s && mode_q != FM_OFF) |=> active_q);
    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && mode_latches(mode_q) && !clr) |=> active_q);
    // R6
    cbc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && mode_q == FM_CBC && !tick) |=> active_q);
    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == FM_OFF) |=> !active_q);
    // R12
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q && !clr) |=> sticky_q);

endmodule

// File: rtl/pwm_fg_pair.sv
// Gating for one complementary output pair: its fault cell, its current-limit
// latch, its safe-level register and the output register.
// Assumes flt_s and clim_s are synchronised and that fs_active comes from a register.
module pwm_fg_pair
    import pwm_fg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_hi,
    input  logic       raw_lo,
    input  logic       flt_s,
    input  logic       clim_s,
    input  logic       fs_active,
    input  logic       tick,
    input  logic       cfg_wr,
    input  logic [1:0] mode_wdata,
    input  logic [1:0] safe_wdata,
    input  logic       clr,
    input  logic       pwm_en,
    output logic       hi_o,
    output logic       lo_o,
    output logic       sticky_o
);

    logic       flt_active;
    logic       clim_q;
    logic [1:0] safe_q;
    logic       override;
    logic       hi_q, lo_q;

    pwm_fg_cell #(
        .RST_ACTIVE (1'b0),
        .RST_MODE   (FM_OFF)
    ) u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .flt_s      (flt_s),
        .tick       (tick),
        .mode_wr    (cfg_wr),
        .mode_wdata (mode_wdata),
        .clr        (clr),
        .active_o   (flt_active),
        .sticky_o   (sticky_o)
    );

    // Current-limit latch: set on the input, released at a tick once the input is low.
    always_ff @(posedge clk) begin
        if (!rst_n)                  clim_q <= 1'b0;
        else if (clim_s)             clim_q <= 1'b1;
        else if (tick)               clim_q <= 1'b0;
    end

    // Safe-level register: {high, low}.
    always_ff @(posedge clk) begin
        if (!rst_n)      safe_q <= 2'b00;
        else if (cfg_wr) safe_q <= safe_wdata;
    end

    // Any active protection source overrides the raw signals.
    always_comb override = flt_active || clim_q || fs_active;

    // Output register: safe levels, idle low, or the raw signals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else if (override) begin
            hi_q <= safe_q[1];
            lo_q <= safe_q[0];
        end else if (!pwm_en) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= raw_hi;
            lo_q <= raw_lo;
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

    // R13
    safe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        override |=> ({hi_q, lo_q} == $past(safe_q)));
    // R11
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!override && !pwm_en) |=> (!hi_q && !lo_q));
    // R9
    clim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clim_q && !tick) |=> clim_q);

endmodule

// File: rtl/pwm_fault_guard.sv
// Top of the PWM fault guard. It synchronises every protection input, holds
// the fail-safe fault cell and builds one gating slice per output pair.
// Assumes tick_i and the write and clear strobes are synchronous to clk.
module pwm_fault_guard
    import pwm_fg_pkg::*;
#(
    parameter int NP   = 3,
    localparam int SELW = $clog2(NP + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NP-1:0]   pwm_hi_i,
    input  logic [NP-1:0]   pwm_lo_i,
    input  logic [NP-1:0]   flt_i,
    input  logic [NP-1:0]   clim_i,
    input  logic            fs_flt_i,
    input  logic            tick_i,
    input  logic            wr_en_i,
    input  logic [SELW-1:0] wr_sel_i,
    input  logic [1:0]      wr_mode_i,
    input  logic [1:0]      wr_safe_i,
    input  logic [NP:0]     clr_i,
    input  logic            pwm_en_i,
    output logic [NP-1:0]   pwm_hi_o,
    output logic [NP-1:0]   pwm_lo_o,
    output logic [NP-1:0]   flt_stat_o,
    output logic            fs_stat_o
);

    localparam int SW = 2 * NP + 1;

    logic [SW-1:0] raw_prot, sync_prot;
    logic [NP-1:0] flt_s, clim_s;
    logic          fs_s;
    logic          fs_active;

    // Collect every protection input into one synchroniser.
    always_comb raw_prot = {fs_flt_i, clim_i, flt_i};

    pwm_fg_sync #(
        .W      (SW),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_prot),
        .dout  (sync_prot)
    );

    // Split the synchronised vector back into its sources.
    always_comb begin
        flt_s  = sync_prot[NP-1:0];
        clim_s = sync_prot[2*NP-1:NP];
        fs_s   = sync_prot[SW-1];
    end

    pwm_fg_cell #(
        .RST_ACTIVE (1'b1),
        .RST_MODE   (FM_LATCH)
    ) u_fs_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .flt_s      (fs_s),
        .tick       (tick_i),
        .mode_wr    (wr_en_i && (wr_sel_i == SELW'(NP))),
        .mode_wdata (wr_mode_i),
        .clr        (clr_i[NP]),
        .active_o   (fs_active),
        .sticky_o   (fs_stat_o)
    );

    for (genvar k = 0; k < NP; k++) begin : g_pair
        pwm_fg_pair u_pair (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw_hi     (pwm_hi_i[k]),
            .raw_lo     (pwm_lo_i[k]),
            .flt_s      (flt_s[k]),
            .clim_s     (clim_s[k]),
            .fs_active  (fs_active),
            .tick       (tick_i),
            .cfg_wr     (wr_en_i && (wr_sel_i == SELW'(k))),
            .mode_wdata (wr_mode_i),
            .safe_wdata (wr_safe_i),
            .clr        (clr_i[k]),
            .pwm_en     (pwm_en_i),
            .hi_o       (pwm_hi_o[k]),
            .lo_o       (pwm_lo_o[k]),
            .sticky_o   (flt_stat_o[k])
        );
    end

    // R1
    reset_safe_chk: assert property (@(posedge clk)
        !rst_n |=> (fs_stat_o && (pwm_hi_o == '0) && (pwm_lo_o == '0)));
    // R2
    fs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_active && fs_s) |=> fs_active);

endmodule

// File: tb/pwm_fault_guard_tb.sv
// Scoreboard bench. The driver pushes the expected pins and status bits into a
// queue. The monitor pops each entry and compares it half a cycle away from the edge.
module pwm_fault_guard_tb;

    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pwm_hi_i = 3'b101, pwm_lo_i = 3'b010;
    logic [NP-1:0] flt_i = '0, clim_i = '0;
    logic          fs_flt_i = 1'b0, tick_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [1:0]    wr_sel_i = '0, wr_mode_i = '0, wr_safe_i = '0;
    logic [NP:0]   clr_i = '0;
    logic          pwm_en_i = 1'b1;
    logic [NP-1:0] pwm_hi_o, pwm_lo_o, flt_stat_o;
    logic          fs_stat_o;

    always #4 clk = ~clk;

    pwm_fault_guard #(.NP(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_hi_i(pwm_hi_i), .pwm_lo_i(pwm_lo_i),
        .flt_i(flt_i), .clim_i(clim_i), .fs_flt_i(fs_flt_i), .tick_i(tick_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_mode_i(wr_mode_i),
        .wr_safe_i(wr_safe_i), .clr_i(clr_i), .pwm_en_i(pwm_en_i),
        .pwm_hi_o(pwm_hi_o), .pwm_lo_o(pwm_lo_o), .flt_stat_o(flt_stat_o),
        .fs_stat_o(fs_stat_o)
    );

    typedef struct {
        logic [2:0] hi;
        logic [2:0] lo;
        logic [3:0] st;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Monitor: compare every queued expectation 1 ns after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (pwm_hi_o !== e.hi || pwm_lo_o !== e.lo ||
                    {fs_stat_o, flt_stat_o} !== e.st) begin
                    n_bad++;
                    $display("FAIL %s: got hi=%b lo=%b st=%b expected hi=%b lo=%b st=%b",
                             e.tag, pwm_hi_o, pwm_lo_o, {fs_stat_o, flt_stat_o},
                             e.hi, e.lo, e.st);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic [2:0] hi, input logic [2:0] lo,
                              input logic [3:0] st, input string tag);
        exp_t e;
        e.hi = hi; e.lo = lo; e.st = st; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [1:0] mode, input logic [1:0] safe);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_mode_i = mode; wr_safe_i = safe;
        cyc(1);
        wr_en_i = 1'b0;
    endtask

    task automatic clr(input logic [3:0] m);
        clr_i = m;
        cyc(1);
        clr_i = '0;
    endtask

    task automatic tick();
        tick_i = 1'b1;
        cyc(1);
        tick_i = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Driver
    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        expect_out(3'b000, 3'b000, 4'b1000, "R1 reset safe");
        cyc(3);
        expect_out(3'b000, 3'b000, 4'b1000, "R1 held safe");

        wr(2'd0, 2'b00, 2'b10);
        wr(2'd1, 2'b01, 2'b01);
        wr(2'd2, 2'b11, 2'b11);
        cyc(1);
        expect_out(3'b101, 3'b110, 4'b1000, "R13 safe levels");

        // Fail-safe fault: a clear while the input is high is ignored
        fs_flt_i = 1'b1;
        cyc(4);
        clr(4'b1000);
        cyc(2);
        expect_out(3'b101, 3'b110, 4'b1000, "R3 clear ignored");

        // Mode rewrite while the fault is active
        wr(2'd3, 2'b01, 2'b00);
        fs_flt_i = 1'b0;
        cyc(4);
        expect_out(3'b101, 3'b110, 4'b1000, "R6 no release before tick");
        tick();
        cyc(1);
        expect_out(3'b101, 3'b010, 4'b1000, "R4 mode write took effect");
        clr(4'b1000);
        expect_out(3'b101, 3'b010, 4'b0000, "R12 status cleared");

        // Raw pass-through and enable
        pwm_hi_i = 3'b011; pwm_lo_i = 3'b100;
        cyc(1);
        expect_out(3'b011, 3'b100, 4'b0000, "R10 raw one edge");
        pwm_en_i = 1'b0;
        cyc(1);
        expect_out(3'b000, 3'b000, 4'b0000, "R11 disabled low");
        pwm_en_i = 1'b1;
        pwm_hi_i = 3'b010; pwm_lo_i = 3'b101;
        cyc(1);
        expect_out(3'b010, 3'b101, 4'b0000, "R11 enabled again");

        // Pair 0 latched
        flt_i[0] = 1'b1;
        cyc(3);
        expect_out(3'b010, 3'b101, 4'b0001, "R10 not yet at pins");
        cyc(1);
        expect_out(3'b011, 3'b100, 4'b0001, "R10 override at 4th edge");
        flt_i[0] = 1'b0;
        cyc(3);
        tick();
        cyc(1);
        expect_out(3'b011, 3'b100, 4'b0001, "R5 latched ignores tick");
        clr(4'b0001);
        cyc(1);
        expect_out(3'b010, 3'b101, 4'b0000, "R5 cleared");

        // Pair 1 cycle-by-cycle
        flt_i[1] = 1'b1;
        cyc(4);
        expect_out(3'b000, 3'b111, 4'b0010, "R6 set");
        tick();
        cyc(1);
        expect_out(3'b000, 3'b111, 4'b0010, "R6 input high holds");
        flt_i[1] = 1'b0;
        cyc(4);
        expect_out(3'b000, 3'b111, 4'b0010, "R6 waits for tick");
        tick();
        cyc(1);
        expect_out(3'b010, 3'b101, 4'b0010, "R12 status kept after release");
        clr(4'b0010);
        expect_out(3'b010, 3'b101, 4'b0000, "R12 status cleared");

        // Pair 2 disabled
        flt_i[2] = 1'b1;
        cyc(5);
        expect_out(3'b010, 3'b101, 4'b0000, "R8 fault ignored");
        flt_i[2] = 1'b0;

        // Pair 2 current limit
        clim_i[2] = 1'b1;
        cyc(4);
        expect_out(3'b110, 3'b101, 4'b0000, "R9 limit override");
        clim_i[2] = 1'b0;
        cyc(3);
        expect_out(3'b110, 3'b101, 4'b0000, "R9 holds until tick");
        tick();
        cyc(1);
        expect_out(3'b010, 3'b101, 4'b0000, "R9 released");

        // Reserved mode behaves as latched
        wr(2'd1, 2'b10, 2'b01);
        flt_i[1] = 1'b1;
        cyc(4);
        expect_out(3'b000, 3'b111, 4'b0010, "R7 set");
        flt_i[1] = 1'b0;
        cyc(3);
        tick();
        cyc(1);
        expect_out(3'b000, 3'b111, 4'b0010, "R7 ignores tick");
        clr(4'b0010);
        cyc(1);
        expect_out(3'b010, 3'b101, 4'b0000, "R7 cleared");

        // Fail-safe fault latched over all pairs
        wr(2'd3, 2'b00, 2'b00);
        fs_flt_i = 1'b1;
        cyc(4);
        expect_out(3'b101, 3'b110, 4'b1000, "R2 all pairs safe");
        fs_flt_i = 1'b0;
        cyc(3);
        clr(4'b1000);
        cyc(1);
        expect_out(3'b010, 3'b101, 4'b0000, "R2 released by clear");

        // Reset re-arms the fail-safe fault
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        expect_out(3'b000, 3'b000, 4'b1000, "R1 re-armed after reset");

        cyc(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule